// File: doc/BRIEF.md
# Serial Line-Card Control Register

This block holds the control word for one telephone line-interface card. A line controller sends an 8-bit word one bit per rising edge of the 2.048 MHz bit clock, most significant bit first. Bits are accepted only while the active-low chip select and the active-low frame sync are both low. When chip select returns high, the received word is copied into the output register in a single cycle. The outputs are never updated from a partly received word.

The stored word drives these outputs:
- three active-low relay enables: ringing, test relay one and test relay two;
- a receive-gain select;
- a polarity-reversal command;
- three general-purpose outputs, which carry inverted copies of the top three bits.

An external gain pin can take over the gain select when it is marked as driven. A ring-trip input reports an off-hook condition during ringing. It forces the ringing relay off and holds it off until software writes a word that stops ringing.

Top module: `line_ctl_reg`

## Requirements
- R1: After a synchronous active-low reset, the outputs are: all three relay enables high, `pol_rev` low, `gain_hi` high and `gpo` all zero. This is the same as a stored word of 8'hFF.
- R2: Shifting takes place on a rising clock edge at which `cs_n` and `fs_n` are both low. The bit on `sdi` enters at the least significant end, so the word is received MSB first. If more than 8 bits are shifted, the last 8 bits received form the word.
- R3: The stored word changes only at the first rising edge at which `cs_n` is high after being low. It changes only if at least 8 bits were shifted during that select. A shorter select leaves every output unchanged.
- R4: `ring_rly_n` follows bit 0 (0 turns ringing on) while no ring trip is latched. `test_rly1_n` follows bit 1 and `test_rly2_n` follows bit 4. A 0 in bit 1 or bit 4 turns on the matching relay.
- R5: While `gs_drive` is low, `gain_hi` equals bit 2 (1 selects -3.5 dB, 0 selects -7.0 dB). While `gs_drive` is high, `gain_hi` equals `gs_pin`, whatever bit 2 holds.
- R6: `pol_rev` is high exactly when bit 3 of the stored word is 0.
- R7: `gpo[i]` is the inverse of bit 5+i of the stored word, for i = 0, 1 and 2.
- R8: A high `ring_trip` at a rising edge makes `ring_rly_n` high from the next cycle on. It stays high, even through words with bit 0 = 0, until a word with bit 0 = 1 is committed in a cycle where `ring_trip` is low.
- R9: Bits presented while `fs_n` is high are not shifted in. A select whose only bits arrived that way commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| fs_n | input | 1 | Frame sync, active low, enables shifting |
| sdi | input | 1 | Serial control data, MSB first |
| gs_drive | input | 1 | High when the external gain pin is driven |
| gs_pin | input | 1 | External gain level (1 = -3.5 dB) |
| ring_trip | input | 1 | Off-hook during ringing detected |
| ring_rly_n | output | 1 | Ringing relay enable, active low |
| test_rly1_n | output | 1 | First test relay enable, active low |
| test_rly2_n | output | 1 | Second test relay enable, active low |
| gain_hi | output | 1 | Receive gain select, 1 = -3.5 dB |
| pol_rev | output | 1 | Tip/ring polarity reversal command |
| gpo | output | 3 | Inverted general-purpose bits 7..5 |

## Verification
Every output is a direct, unregistered decode of the stored word and the trip latch. A wrong stored bit therefore shows at its output pin in the cycle after the commit edge. A trip latch that fails to set or to clear shows on `ring_rly_n` one cycle after the trip edge or the commit edge. A miscounting shift counter shows up in two ways: a short select changes the outputs when it should not, or a full select leaves them unchanged. In either case the error is visible right after `cs_n` rises. An off-by-one in shift order shows as the wrong bit on a relay or general-purpose pin.

// File: rtl/lcr_pkg.sv
// Package: shared widths and bit positions of the line-card control word.
// Assumes an 8-bit word; bit positions are fixed because outputs decode them.
package lcr_pkg;
    localparam int WORD_W   = 8;
    localparam int POS_RING = 0;
    localparam int POS_TST1 = 1;
    localparam int POS_GAIN = 2;
    localparam int POS_POL  = 3;
    localparam int POS_TST2 = 4;
    localparam int POS_GPO  = 5;
    localparam int GPO_N    = 3;

    // Decoded output bundle produced from the stored word.
    typedef struct packed {
        logic             ring_n;
        logic             tst1_n;
        logic             tst2_n;
        logic             gain_hi;
        logic             pol_rev;
        logic [GPO_N-1:0] gpo;
    } lcr_out_t;
endpackage

// File: rtl/lcr_shift.sv
// Module: serial receiver. Shifts sdi in, MSB first, while cs_n and fs_n
// are low; raises commit for one cycle when cs_n rises after a select of
// at least W bits. Assumes cs_n and fs_n are already synchronous to clk.
module lcr_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         fs_n,
    input  logic         sdi,
    output logic [W-1:0] shreg,
    output logic         commit
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    logic [CNT_W-1:0] cnt;
    logic             cs_q;

    // Purpose: shift data, count bits (saturating) and remember last select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            cnt   <= '0;
            cs_q  <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                cnt <= '0;
            end else if (!fs_n) begin
                shreg <= {shreg[W-2:0], sdi};
                if (cnt != FULL) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Purpose: commit on rising select when a full word was received.
    always_comb begin
        commit = cs_n && !cs_q && (cnt == FULL);
    end
endmodule

// File: rtl/lcr_latch.sv
// Module: holding register for the control word. Loads the shifted word
// on commit; resets to all ones (everything inactive, -3.5 dB gain).
module lcr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic [W-1:0] din,
    output logic [W-1:0] word
);
    // Purpose: keep the active word, replaced only by a committed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '1;
        end else if (commit) begin
            word <= din;
        end
    end
endmodule

// File: rtl/lcr_trip.sv
// Module: ring-trip interlock. Any ring_trip sets the latch; a committed
// word with the ringing bit at 1 clears it unless a trip arrives the same
// cycle, in which case the set wins.
module lcr_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_trip,
    input  logic commit,
    input  logic new_ring_bit,
    output logic tripped
);
    // Purpose: hold the off-hook override until ringing is withdrawn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tripped <= 1'b0;
        end else if (ring_trip) begin
            tripped <= 1'b1;
        end else if (commit && new_ring_bit) begin
            tripped <= 1'b0;
        end
    end
endmodule

// File: rtl/lcr_map.sv
// Module: decodes the stored word into output pins. Purely combinational;
// assumes gs_pin is only meaningful while gs_drive is high.
module lcr_map
    import lcr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              tripped,
    input  logic              gs_drive,
    input  logic              gs_pin,
    output lcr_out_t          outs
);
    // Purpose: relay, gain and polarity decode.
    always_comb begin
        outs.ring_n  = word[POS_RING] | tripped;
        outs.tst1_n  = word[POS_TST1];
        outs.tst2_n  = word[POS_TST2];
        outs.gain_hi = gs_drive ? gs_pin : word[POS_GAIN];
        outs.pol_rev = ~word[POS_POL];
    end

    // Purpose: inverted general-purpose bits, one per generated slice.
    for (genvar g = 0; g < GPO_N; g++) begin : g_gpo
        assign outs.gpo[g] = ~word[POS_GPO + g];
    end
endmodule

// File: rtl/line_ctl_reg.sv
// Module: top of the serial line-card control register. Joins receiver,
// holding register, ring-trip interlock and output decode.
module line_ctl_reg
    import lcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             fs_n,
    input  logic             sdi,
    input  logic             gs_drive,
    input  logic             gs_pin,
    input  logic             ring_trip,
    output logic             ring_rly_n,
    output logic             test_rly1_n,
    output logic             test_rly2_n,
    output logic             gain_hi,
    output logic             pol_rev,
    output logic [GPO_N-1:0] gpo
);
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] word;
    logic              commit;
    logic              tripped;
    lcr_out_t          outs;

    lcr_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs_n(fs_n), .sdi(sdi),
        .shreg(shreg), .commit(commit)
    );

    lcr_latch #(.W(WORD_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .commit(commit), .din(shreg), .word(word)
    );

    lcr_trip u_trip (
        .clk(clk), .rst_n(rst_n), .ring_trip(ring_trip), .commit(commit),
        .new_ring_bit(shreg[POS_RING]), .tripped(tripped)
    );

    lcr_map u_map (
        .word(word), .tripped(tripped), .gs_drive(gs_drive),
        .gs_pin(gs_pin), .outs(outs)
    );

    // Purpose: drive the port pins from the decoded bundle.
    always_comb begin
        ring_rly_n  = outs.ring_n;
        test_rly1_n = outs.tst1_n;
        test_rly2_n = outs.tst2_n;
        gain_hi     = outs.gain_hi;
        pol_rev     = outs.pol_rev;
        gpo         = outs.gpo;
    end
endmodule

// File: rtl/lcr_chk.sv
// Module: property checker for line_ctl_reg, attached by bind below.
module lcr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       gs_drive,
    input logic       gs_pin,
    input logic       ring_trip,
    input logic       ring_rly_n,
    input logic       test_rly1_n,
    input logic       test_rly2_n,
    input logic       gain_hi,
    input logic       pol_rev,
    input logic [2:0] gpo
);
    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> $stable({test_rly1_n, test_rly2_n, pol_rev, gpo}));

    // R3
    ring_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ring_rly_n) |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R8
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_trip |=> ring_rly_n);

    // R5
    gain_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gs_drive |-> (gain_hi == gs_pin));

    // R3
    pol_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(pol_rev) |-> ($past(cs_n) && !$past(cs_n, 2)));
endmodule

bind line_ctl_reg lcr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .gs_drive(gs_drive),
    .gs_pin(gs_pin), .ring_trip(ring_trip), .ring_rly_n(ring_rly_n),
    .test_rly1_n(test_rly1_n), .test_rly2_n(test_rly2_n),
    .gain_hi(gain_hi), .pol_rev(pol_rev), .gpo(gpo)
);

// File: tb/sim_line_ctl_reg.sv
module sim_line_ctl_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, fs_n = 1'b1, sdi = 1'b0;
    logic gs_drive = 1'b0, gs_pin = 1'b0, ring_trip = 1'b0;
    logic ring_rly_n, test_rly1_n, test_rly2_n, gain_hi, pol_rev;
    logic [2:0] gpo;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    line_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs_n(fs_n), .sdi(sdi),
        .gs_drive(gs_drive), .gs_pin(gs_pin), .ring_trip(ring_trip),
        .ring_rly_n(ring_rly_n), .test_rly1_n(test_rly1_n),
        .test_rly2_n(test_rly2_n), .gain_hi(gain_hi), .pol_rev(pol_rev),
        .gpo(gpo)
    );

    // Vector: {word, gs_drive, gs_pin}
    localparam logic [9:0] VEC [8] = '{
        {8'h00, 2'b00}, {8'hFF, 2'b00}, {8'hA5, 2'b00}, {8'h5A, 2'b00},
        {8'hFF, 2'b10}, {8'hFB, 2'b11}, {8'h3C, 2'b00}, {8'hC3, 2'b00}
    };

    // Expected pins {ring,t1,t2,gain,pol,gpo[2:0]} from the requirements.
    function automatic logic [7:0] expect_pins(input logic [7:0] w, input logic trip,
                                               input logic gd, input logic gp);
        logic [7:0] e;
        e[7]   = w[0] | trip;
        e[6]   = w[1];
        e[5]   = w[4];
        e[4]   = gd ? gp : w[2];
        e[3]   = (w[3] == 1'b0);
        e[2:0] = {~w[7], ~w[6], ~w[5]};
        return e;
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        logic [7:0] act;
        act = {ring_rly_n, test_rly1_n, test_rly2_n, gain_hi, pol_rev, gpo};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Shift n bits of d (MSB d[n-1] first) with the given frame sync level.
    task automatic send(input logic [15:0] d, input int n, input logic fsv);
        @(negedge clk);
        cs_n = 1'b0;
        fs_n = fsv;
        for (int i = n - 1; i >= 0; i--) begin
            sdi = d[i];
            @(negedge clk);
        end
        cs_n = 1'b1;
        fs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", expect_pins(8'hFF, 1'b0, 1'b0, 1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", expect_pins(8'hFF, 1'b0, 1'b0, 1'b0));

        // R2 R4 R5 R6 R7 table walk
        for (int k = 0; k < 8; k++) begin
            gs_drive = VEC[k][1];
            gs_pin   = VEC[k][0];
            send({8'h00, VEC[k][9:2]}, 8, 1'b0);
            check($sformatf("R2 R4 R5 R6 R7 vec%0d", k),
                  expect_pins(VEC[k][9:2], 1'b0, VEC[k][1], VEC[k][0]));
        end
        gs_drive = 1'b0;

        // R3 short select discarded (stored word is 8'hC3)
        send(16'h0000, 5, 1'b0);
        check("R3 short word", expect_pins(8'hC3, 1'b0, 1'b0, 1'b0));

        // R3 outputs hold while shifting
        @(negedge clk);
        cs_n = 1'b0; fs_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            sdi = 1'b0;
            @(negedge clk);
        end
        check("R3 mid shift", expect_pins(8'hC3, 1'b0, 1'b0, 1'b0));
        cs_n = 1'b1; fs_n = 1'b1;
        @(negedge clk);

        // R9 bits with frame sync high are ignored
        send(16'h0000, 8, 1'b1);
        check("R9 fs high", expect_pins(8'hC3, 1'b0, 1'b0, 1'b0));

        // R2 more than 8 bits: last 8 kept
        send(16'h03B6, 10, 1'b0);
        check("R2 ten bits", expect_pins(8'hB6, 1'b0, 1'b0, 1'b0));

        // R8 ring trip interlock
        send(16'h00FE, 8, 1'b0);
        check("R4 ringing on", expect_pins(8'hFE, 1'b0, 1'b0, 1'b0));
        ring_trip = 1'b1;
        @(negedge clk);
        ring_trip = 1'b0;
        check("R8 trip", expect_pins(8'hFE, 1'b1, 1'b0, 1'b0));
        send(16'h00FE, 8, 1'b0);
        check("R8 held by bit0=0", expect_pins(8'hFE, 1'b1, 1'b0, 1'b0));
        send(16'h00FF, 8, 1'b0);
        check("R8 cleared word", expect_pins(8'hFF, 1'b0, 1'b0, 1'b0));
        send(16'h00FE, 8, 1'b0);
        check("R8 ringing again", expect_pins(8'hFE, 1'b0, 1'b0, 1'b0));

        // R8 trip on the commit edge wins over a clearing word
        ring_trip = 1'b1;
        @(negedge clk);
        ring_trip = 1'b0;
        @(negedge clk);
        cs_n = 1'b0; fs_n = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sdi = 1'b1;
            @(negedge clk);
        end
        cs_n = 1'b1; fs_n = 1'b1; ring_trip = 1'b1;
        @(negedge clk);
        ring_trip = 1'b0;
        send(16'h00FE, 8, 1'b0);
        check("R8 set wins", expect_pins(8'hFE, 1'b1, 1'b0, 1'b0));

        // R5 pin override toggled without a new word
        gs_drive = 1'b1; gs_pin = 1'b0;
        #1;
        check("R5 pin low", expect_pins(8'hFE, 1'b1, 1'b1, 1'b0));
        gs_drive = 1'b0;

        // R1 reset mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset", expect_pins(8'hFF, 1'b0, 1'b0, 1'b0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule